// File: doc/BRIEF.md
# Duty-Cycle Voltage Interpolation Selector

This block is the digital half of a source-driver output channel that reaches 8-bit grey levels without a full-resolution converter. The high part of each pixel code names a pair of adjacent reference-voltage taps. The low part sets how many slots of a 32-slot period the output spends on the upper tap of that pair. For the rest of the period the output sits on the lower tap. The data line acts as a low-pass filter, so the pixel settles at the weighted average of the two tap voltages. The analog switches and the averaging are outside this block.

A period-start strobe loads a new code and restarts the slot counter. The code is taken only at that strobe, so the ratio cannot change partway through a period. With the low field equal to f, the channel spends f slots on the upper tap and 32−f slots on the lower tap. This gives ratios from 31:1 down to 0:32. When no new strobe arrives, the counter wraps and the same pattern repeats.

Top module: `duty_interp_sel`

## Requirements
- R1: While synchronous active-low reset is applied, and after it until the first strobe, tap_lo is 0, tap_hi is 1 and sel_hi is 0.
- R2: On a clock edge where period_start is 1, the block loads code. From the next cycle tap_lo equals code[7:5] as loaded.
- R3: tap_hi always equals tap_lo + 1, as a 4-bit value. A code with code[7:5] = 7 therefore gives tap_hi = 8.
- R4: Slots are numbered 0 to 31, and slot 0 is the first cycle after the strobe edge. With f = code[4:0] as loaded, sel_hi is 1 (upper tap) in slots 0 to f−1 and 0 (lower tap) in slots f to 31.
- R5: The end ratios are fixed. f = 0 holds sel_hi at 0 for all 32 slots (0:32). f = 31 gives 31 slots at 1 followed by a single slot at 0 (31:1).
- R6: A change of code while period_start is 0 has no effect on tap_lo, tap_hi or sel_hi.
- R7: If no strobe arrives, the slot count wraps from 31 to 0 and the pattern of the held code repeats period after period.
- R8: A strobe in the middle of a period ends that period at once. The new code's pattern starts at slot 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period slot per cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| period_start | input | 1 | Loads code and restarts the slot count |
| code | input | 8 | Pixel code: [7:5] tap pair, [4:0] upper-tap slot count |
| tap_lo | output | 3 | Index of the lower reference tap |
| tap_hi | output | 4 | Index of the upper reference tap |
| sel_hi | output | 1 | 1 selects the upper tap, 0 the lower tap |

## Verification
A wrong slot count shows up as a misplaced rising edge of sel_hi or a wrong number of high slots. Because every period starts with its high run, this is visible within one period of 32 cycles. A base register that loads at the wrong time, or fails to hold, shows on tap_lo and tap_hi in the first cycle after the strobe, or in the cycle after the stray code change. A mishandled wrap or restart shows in the first slot that follows it. The bench therefore compares sel_hi in every slot of each period it drives, rather than only the average.

// File: rtl/duty_interp_pkg.sv
// Package: shared types for the duty-cycle interpolation selector.
// Assumes: sel_hi is encoded 1 = upper tap, 0 = lower tap.
package duty_interp_pkg;
    typedef enum logic {
        TAP_LOWER = 1'b0,
        TAP_UPPER = 1'b1
    } tap_pick_e;

    // Decides which tap a slot uses, given the slot number and the loaded fraction.
    function automatic tap_pick_e pick_for_slot(input logic [7:0] slot, input logic [7:0] frac);
        return (slot < frac) ? TAP_UPPER : TAP_LOWER;
    endfunction
endpackage

// File: rtl/duty_slot_ctr.sv
// Module: slot counter for one interpolation period.
// Counts 0..2**FRAC_W-1 and wraps freely.
// A restart forces the count to 0 on the same edge.
// Assumes: synchronous active-low reset.
module duty_slot_ctr #(
    parameter int FRAC_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    output logic [FRAC_W-1:0] slot
);
    logic [FRAC_W-1:0] slot_q;

    // Advance the slot number; a restart sets it to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else if (restart) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_q + 1'b1;
        end
    end

    assign slot = slot_q;
endmodule

// File: rtl/duty_code_latch.sv
// Module: holds the pixel code for one period and decodes the tap pair.
// Assumes: load is the period-start strobe. The code is captured only then.
module duty_code_latch #(
    parameter int CODE_W = 8,
    parameter int FRAC_W = 5,
    localparam int BASE_W = CODE_W - FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CODE_W-1:0] code,
    output logic [FRAC_W-1:0] frac,
    output logic [BASE_W-1:0] tap_lo,
    output logic [BASE_W:0]   tap_hi
);
    logic [BASE_W-1:0] base_q;
    logic [FRAC_W-1:0] frac_q;

    // Capture both code fields at period start only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            frac_q <= '0;
        end else if (load) begin
            base_q <= code[CODE_W-1:FRAC_W];
            frac_q <= code[FRAC_W-1:0];
        end
    end

    // Form the neighbouring tap pair from the held base.
    always_comb begin
        tap_lo = base_q;
        tap_hi = {1'b0, base_q} + 1'b1;
    end

    assign frac = frac_q;
endmodule

// File: rtl/duty_pulse_gen.sv
// Module: duty-ratio select pulse.
// The pulse is high in the first frac slots of a period and low in the rest.
// Assumes: slot and frac both come from registers, so the output has no hazards.
module duty_pulse_gen #(
    parameter int FRAC_W = 5
) (
    input  logic [FRAC_W-1:0] slot,
    input  logic [FRAC_W-1:0] frac,
    output logic              sel_hi
);
    import duty_interp_pkg::*;

    tap_pick_e pick;

    // Compare the slot with the fraction to choose the tap.
    always_comb begin
        pick   = pick_for_slot(8'(slot), 8'(frac));
        sel_hi = (pick == TAP_UPPER);
    end
endmodule

// File: rtl/duty_interp_sel.sv
// Module: top of the duty-cycle voltage interpolation selector.
// A strobe loads the code and restarts a 2**FRAC_W-slot period.
// The outputs name two adjacent taps and a pulse that alternates between them.
// Assumes: synchronous active-low reset; FRAC_W <= 8.
module duty_interp_sel #(
    parameter int CODE_W = 8,
    parameter int FRAC_W = 5,
    localparam int BASE_W = CODE_W - FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              period_start,
    input  logic [CODE_W-1:0] code,
    output logic [BASE_W-1:0] tap_lo,
    output logic [BASE_W:0]   tap_hi,
    output logic              sel_hi
);
    logic [FRAC_W-1:0] slot;
    logic [FRAC_W-1:0] frac;

    duty_slot_ctr #(.FRAC_W(FRAC_W)) ctr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (period_start),
        .slot    (slot)
    );

    duty_code_latch #(.CODE_W(CODE_W), .FRAC_W(FRAC_W)) latch_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (period_start),
        .code   (code),
        .frac   (frac),
        .tap_lo (tap_lo),
        .tap_hi (tap_hi)
    );

    duty_pulse_gen #(.FRAC_W(FRAC_W)) pulse_i (
        .slot   (slot),
        .frac   (frac),
        .sel_hi (sel_hi)
    );
endmodule

// File: rtl/duty_interp_chk.sv
// Module: assertion checker for duty_interp_sel, attached by bind.
// Keeps its own slot count to check where the pulse may rise.
module duty_interp_chk #(
    parameter int CODE_W = 8,
    parameter int FRAC_W = 5,
    localparam int BASE_W = CODE_W - FRAC_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              period_start,
    input logic [CODE_W-1:0] code,
    input logic [BASE_W-1:0] tap_lo,
    input logic [BASE_W:0]   tap_hi,
    input logic              sel_hi
);
    logic [FRAC_W-1:0] chk_slot;

    // Independent slot count used by the rise check.
    always_ff @(posedge clk) begin
        if (!rst_n || period_start) chk_slot <= '0;
        else                        chk_slot <= chk_slot + 1'b1;
    end

    AST_LOAD_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        period_start |=> tap_lo == $past(code[CODE_W-1:FRAC_W])); // R2
    AST_TAP_ADJACENT: assert property (@(posedge clk) disable iff (!rst_n)
        tap_hi == {1'b0, tap_lo} + 1'b1); // R3
    AST_FIRST_SLOT_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (period_start && code[FRAC_W-1:0] != '0) |=> sel_hi); // R4
    AST_ZERO_FRAC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (period_start && code[FRAC_W-1:0] == '0) |=> !sel_hi); // R5
    AST_HOLD_TAPS: assert property (@(posedge clk) disable iff (!rst_n)
        !period_start |=> ($stable(tap_lo) && $stable(tap_hi))); // R6
    AST_RISE_AT_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_hi) |-> chk_slot == '0); // R7
endmodule

bind duty_interp_sel duty_interp_chk #(.CODE_W(CODE_W), .FRAC_W(FRAC_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .period_start (period_start),
    .code         (code),
    .tap_lo       (tap_lo),
    .tap_hi       (tap_hi),
    .sel_hi       (sel_hi)
);

// File: tb/duty_interp_sel_tb.sv
`timescale 1ns/1ps
// Bench: directed scenarios for duty_interp_sel, one task per scenario.
module duty_interp_sel_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       period_start = 1'b0;
    logic [7:0] code = 8'h00;
    logic [2:0] tap_lo;
    logic [3:0] tap_hi;
    logic       sel_hi;
    int         n_checks = 0;
    int         n_errors = 0;

    always #2 clk = ~clk;

    duty_interp_sel dut_i (
        .clk(clk), .rst_n(rst_n), .period_start(period_start), .code(code),
        .tap_lo(tap_lo), .tap_hi(tap_hi), .sel_hi(sel_hi)
    );

    // Record one comparison.
    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Pulse the strobe with a new code. Returns at the negedge that shows slot 0.
    task automatic strobe(input logic [7:0] c);
        @(negedge clk);
        code = c;
        period_start = 1'b1;
        @(negedge clk);
        period_start = 1'b0;
    endtask

    // Check n slots from slot 0, with the expected base and fraction.
    // If noisy is set, code is scrambled during the period.
    task automatic run_slots(input int base, input int frac, input int n,
                             input bit noisy, input string req);
        for (int i = 0; i < n; i++) begin
            check({req, " sel"}, int'(sel_hi), (i < frac) ? 1 : 0);
            if (i == 0 || i == n - 1) begin
                check({req, " tap_lo"}, int'(tap_lo), base);
                check({req, " R3 tap_hi"}, int'(tap_hi), base + 1);
            end
            if (noisy) code = code ^ 8'hA5;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 tap_lo", int'(tap_lo), 0);
        check("R1 tap_hi", int'(tap_hi), 1);
        check("R1 sel_hi", int'(sel_hi), 0);
    endtask

    task automatic t_patterns();
        strobe(8'b010_00101); run_slots(2, 5, 32, 1'b0, "R2/R4 f5");
        strobe(8'b011_10000); run_slots(3, 16, 32, 1'b0, "R2/R4 f16");
        strobe(8'b001_00001); run_slots(1, 1, 32, 1'b0, "R4 f1");
    endtask

    task automatic t_ends();
        strobe(8'hFF); run_slots(7, 31, 32, 1'b0, "R5 31:1");
        strobe(8'h00); run_slots(0, 0, 32, 1'b0, "R5 0:32");
    endtask

    task automatic t_ignore();
        strobe(8'b101_01010); run_slots(5, 10, 32, 1'b1, "R6 ignore");
    endtask

    task automatic t_wrap();
        strobe(8'b110_00111);
        run_slots(6, 7, 32, 1'b0, "R7 first");
        run_slots(6, 7, 32, 1'b0, "R7 wrap");
    endtask

    task automatic t_restart();
        strobe(8'b100_11000); run_slots(4, 24, 10, 1'b0, "R8 before");
        strobe(8'b010_00011); run_slots(2, 3, 32, 1'b0, "R8 after");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_patterns();
        t_ends();
        t_ignore();
        t_wrap();
        t_restart();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(4 * 50000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule